// File: doc/BRIEF.md
# Dual-Issue Pipe Steering Unit

This block sits between an in-order issue queue and four execution pipes: a complex-integer pipe, a simple-integer pipe, a load/store pipe and a floating-point pipe. Each cycle the queue offers up to two decoded instructions, an older one in slot 0 and a younger one in slot 1. Each instruction carries a class tag and an opaque instruction tag. The unit compares what each class needs with the per-pipe "dispatch stage free" inputs. It answers in the same cycle with a per-slot accept. The pipes it picks receive the instruction tag in registered form on the next clock edge.

Simple integer work can go to either integer pipe. Multiply, divide, trap, branch and special-register moves are bound to the complex pipe. A store-conditional needs the load/store and complex dispatch stages together and is legal only in slot 0. An instruction-sync claims all four pipes at once. Program order is kept: the younger slot never goes without the older one. Operand readiness, decoding and execution belong to other blocks.

Top module: `dual_issue_steer`

## Requirements
- R1: While reset is asserted, and on the first edge after it, every bit of `disp_vld` is 0.
- R2: Class 0 (simple integer) takes the complex pipe (bit 0) if it is free, otherwise the simple pipe (bit 1). If neither is free it is not accepted.
- R3: Class 1 (complex only) is accepted only when pipe bit 0 is free, and it uses that pipe alone.
- R4: Class 2 (load/store) uses only pipe bit 2, and class 3 (floating point) uses only pipe bit 3. Each is accepted exactly when its pipe is free.
- R5: Class 4 (store-conditional) is accepted only when pipe bits 0 and 2 are both free. It then occupies both pipes, and both carry its tag.
- R6: Class 4 in slot 1 is never accepted.
- R7: Class 5 (instruction sync) is accepted only when all four pipes are free, and it occupies all four. When it is accepted in slot 0, slot 1 is not accepted.
- R8: Slot 1 is accepted only in a cycle where slot 0 is also accepted. An invalid or stalled slot 0 holds slot 1.
- R9: When both slots need the same single pipe, only slot 0 is accepted.
- R10: When both slots hold class 0 and pipes 0 and 1 are free, slot 0 takes pipe 0 and slot 1 takes pipe 1. A slot-1 class 0 behind a slot-0 instruction that left pipe 0 free takes pipe 0.
- R11: Class codes 6 and 7 are reserved and never accepted.
- R12: `s0_acc`/`s1_acc` respond combinationally in the same cycle. `disp_vld` and the tag slice of pipe p (`disp_tag[p*TAG_W +: TAG_W]`) show the accepted instructions after the next rising edge, for exactly one cycle.
- R13: A pipe whose free bit is low in a cycle never shows `disp_vld` set after that cycle's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_vld | input | 1 | Slot 0 (older) holds an instruction |
| s0_cls | input | 3 | Slot 0 class code |
| s0_tag | input | TAG_W | Slot 0 instruction tag |
| s1_vld | input | 1 | Slot 1 (younger) holds an instruction |
| s1_cls | input | 3 | Slot 1 class code |
| s1_tag | input | TAG_W | Slot 1 instruction tag |
| pipe_free | input | 4 | Dispatch stage free: bit0 complex, bit1 simple, bit2 load/store, bit3 FP |
| s0_acc | output | 1 | Slot 0 accepted this cycle |
| s1_acc | output | 1 | Slot 1 accepted this cycle |
| disp_vld | output | 4 | Registered per-pipe dispatch valid |
| disp_tag | output | 4*TAG_W | Registered per-pipe tag, pipe p in bits p*TAG_W +: TAG_W |

## Verification
The bench builds the unit with TAG_W set to 6 instead of the default 8. This moves every tag slice onto a new boundary, so an indexing error in the per-pipe tag packing shows up as a wrong tag. Distinct 6-bit tags on the two slots show which slot fed each pipe. This makes the two-pipe store-conditional, the four-pipe sync and the split of two simple ops observable per pipe.

// File: rtl/steer_pkg.sv
package steer_pkg;
    localparam int NUM_PIPES = 4;
    localparam int NUM_SLOTS = 2;
    localparam int CLS_W     = 3;

    localparam int P_CPLX = 0;
    localparam int P_SMPL = 1;
    localparam int P_LDST = 2;
    localparam int P_FP   = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_SIMPLE = 3'd0,
        CLS_CPLX   = 3'd1,
        CLS_LDST   = 3'd2,
        CLS_FP     = 3'd3,
        CLS_STCX   = 3'd4,
        CLS_ISYNC  = 3'd5,
        CLS_RSV6   = 3'd6,
        CLS_RSV7   = 3'd7
    } cls_e;

    typedef logic [NUM_PIPES-1:0] pmask_t;

    typedef struct packed {
        pmask_t fixed;
        logic   flex;
        logic   legal;
        logic   slot0_only;
    } need_t;
endpackage

// File: rtl/steer_cls_dec.sv
module steer_cls_dec
    import steer_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    output need_t            need
);
    always_comb begin
        need = '0;
        case (cls_e'(cls))
            CLS_SIMPLE: begin need.flex = 1'b1; need.legal = 1'b1; end
            CLS_CPLX:   begin need.fixed[P_CPLX] = 1'b1; need.legal = 1'b1; end
            CLS_LDST:   begin need.fixed[P_LDST] = 1'b1; need.legal = 1'b1; end
            CLS_FP:     begin need.fixed[P_FP] = 1'b1; need.legal = 1'b1; end
            CLS_STCX: begin
                need.fixed[P_CPLX] = 1'b1;
                need.fixed[P_LDST] = 1'b1;
                need.legal         = 1'b1;
                need.slot0_only    = 1'b1;
            end
            CLS_ISYNC:  begin need.fixed = '1; need.legal = 1'b1; end
            default:    need = '0;
        endcase
    end
endmodule

// File: rtl/steer_slot.sv
module steer_slot
    import steer_pkg::*;
(
    input  logic   vld,
    input  need_t  need,
    input  logic   allow,
    input  pmask_t free,
    output logic   acc,
    output pmask_t used
);
    pmask_t want;
    logic   fits;

    always_comb begin
        want = '0;
        if (need.flex) begin
            if (free[P_CPLX])      want[P_CPLX] = 1'b1;
            else if (free[P_SMPL]) want[P_SMPL] = 1'b1;
            fits = (want != '0);
        end else begin
            want = need.fixed;
            fits = ((need.fixed & ~free) == '0);
        end
        acc  = vld && need.legal && allow && fits;
        used = acc ? want : '0;
    end
endmodule

// File: rtl/dual_issue_steer.sv
module dual_issue_steer
    import steer_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       s0_vld,
    input  logic [CLS_W-1:0]           s0_cls,
    input  logic [TAG_W-1:0]           s0_tag,
    input  logic                       s1_vld,
    input  logic [CLS_W-1:0]           s1_cls,
    input  logic [TAG_W-1:0]           s1_tag,
    input  logic [NUM_PIPES-1:0]       pipe_free,
    output logic                       s0_acc,
    output logic                       s1_acc,
    output logic [NUM_PIPES-1:0]       disp_vld,
    output logic [NUM_PIPES*TAG_W-1:0] disp_tag
);
    localparam int TAGS_W = NUM_PIPES * TAG_W;

    typedef struct packed {
        pmask_t              vld;
        logic [TAGS_W-1:0]   tag;
    } disp_t;

    logic   [NUM_SLOTS-1:0]            vld_in;
    logic   [NUM_SLOTS-1:0][CLS_W-1:0] cls_in;
    logic   [NUM_SLOTS-1:0][TAG_W-1:0] tag_in;
    need_t  [NUM_SLOTS-1:0]            need;
    logic   [NUM_SLOTS-1:0]            acc;
    logic   [NUM_SLOTS-1:0]            allow;
    pmask_t [NUM_SLOTS-1:0]            used;
    pmask_t [NUM_SLOTS:0]              free_chain;

    disp_t disp_d, disp_q;

    assign vld_in        = {s1_vld, s0_vld};
    assign cls_in        = {s1_cls, s0_cls};
    assign tag_in        = {s1_tag, s0_tag};
    assign free_chain[0] = pipe_free;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        steer_cls_dec u_dec (.cls(cls_in[i]), .need(need[i]));

        if (i == 0) begin : g_head
            assign allow[i] = 1'b1;
        end else begin : g_tail
            // younger slot follows only behind an accepted older slot
            assign allow[i] = acc[i-1] && !need[i].slot0_only;
        end

        steer_slot u_slot (
            .vld  (vld_in[i]),
            .need (need[i]),
            .allow(allow[i]),
            .free (free_chain[i]),
            .acc  (acc[i]),
            .used (used[i])
        );

        assign free_chain[i+1] = free_chain[i] & ~used[i];
    end

    always_comb begin
        disp_d = '0;
        for (int p = 0; p < NUM_PIPES; p++) begin
            for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
                if (used[i][p]) begin
                    disp_d.vld[p]                 = 1'b1;
                    disp_d.tag[p*TAG_W +: TAG_W]  = tag_in[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) disp_q <= '0;
        else        disp_q <= disp_d;
    end

    assign s0_acc   = acc[0];
    assign s1_acc   = acc[1];
    assign disp_vld = disp_q.vld;
    assign disp_tag = disp_q.tag;

    a_r8_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        s1_acc |-> s0_acc);

    a_r6_stcx_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        s1_acc |-> (s1_cls != CLS_STCX));

    a_r7_isync_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_acc && s0_cls == CLS_ISYNC) |-> !s1_acc);

    a_r5_stcx_both: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_acc && s0_cls == CLS_STCX) |=> (disp_vld[P_CPLX] && disp_vld[P_LDST]));

    a_r13_only_free: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((disp_vld & ~$past(pipe_free)) == '0));

    a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_cls[2:1] == 2'b11) |-> !s0_acc);
endmodule

// File: tb/test_dual_issue_steer.sv
module test_dual_issue_steer;
    localparam int TW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          s0_vld, s1_vld;
    logic [2:0]    s0_cls, s1_cls;
    logic [TW-1:0] s0_tag, s1_tag;
    logic [3:0]    pipe_free;
    logic          s0_acc, s1_acc;
    logic [3:0]    disp_vld;
    logic [4*TW-1:0] disp_tag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dual_issue_steer #(.TAG_W(TW)) i_dual_issue_steer (
        .clk(clk), .rst_n(rst_n),
        .s0_vld(s0_vld), .s0_cls(s0_cls), .s0_tag(s0_tag),
        .s1_vld(s1_vld), .s1_cls(s1_cls), .s1_tag(s1_tag),
        .pipe_free(pipe_free),
        .s0_acc(s0_acc), .s1_acc(s1_acc),
        .disp_vld(disp_vld), .disp_tag(disp_tag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // drive one cycle, check accepts, then the registered dispatch
    task automatic step(input string req,
                        input bit v0, input int c0, input int t0,
                        input bit v1, input int c1, input int t1,
                        input logic [3:0] free,
                        input bit ea0, input bit ea1,
                        input logic [3:0] m0, input logic [3:0] m1);
        @(negedge clk);
        s0_vld = v0; s0_cls = 3'(c0); s0_tag = TW'(t0);
        s1_vld = v1; s1_cls = 3'(c1); s1_tag = TW'(t1);
        pipe_free = free;
        #1;
        chk(req, "s0_acc", int'(s0_acc), int'(ea0));
        chk(req, "s1_acc", int'(s1_acc), int'(ea1));
        @(posedge clk); #1;
        chk(req, "disp_vld", int'(disp_vld), int'(m0 | m1));
        for (int p = 0; p < 4; p++) begin
            if (m0[p])      chk(req, "tag", int'(disp_tag[p*TW +: TW]), t0);
            else if (m1[p]) chk(req, "tag", int'(disp_tag[p*TW +: TW]), t1);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        s0_vld = 1'b1; s0_cls = 3'd0; s0_tag = 6'h11;
        s1_vld = 1'b0; s1_cls = 3'd0; s1_tag = '0; pipe_free = 4'hF;
        repeat (3) @(posedge clk);
        #1 chk("R1", "disp_vld in reset", int'(disp_vld), 0);
        @(negedge clk); rst_n = 1'b1; s0_vld = 1'b0;
        @(posedge clk); #1 chk("R1", "disp_vld after reset", int'(disp_vld), 0);
    endtask

    task automatic t_simple;   // R2
        step("R2", 1, 0, 6'h01, 0, 0, 0, 4'b1111, 1, 0, 4'b0001, 4'b0000);
        step("R2", 1, 0, 6'h02, 0, 0, 0, 4'b1110, 1, 0, 4'b0010, 4'b0000);
        step("R2", 1, 0, 6'h03, 0, 0, 0, 4'b1100, 0, 0, 4'b0000, 4'b0000);
    endtask

    task automatic t_complex;  // R3
        step("R3", 1, 1, 6'h04, 0, 0, 0, 4'b1110, 0, 0, 4'b0000, 4'b0000);
        step("R3", 1, 1, 6'h05, 0, 0, 0, 4'b0001, 1, 0, 4'b0001, 4'b0000);
    endtask

    task automatic t_ldst_fp;  // R4
        step("R4", 1, 2, 6'h06, 1, 3, 6'h07, 4'b1111, 1, 1, 4'b0100, 4'b1000);
        step("R4", 1, 3, 6'h08, 0, 0, 0, 4'b0111, 0, 0, 4'b0000, 4'b0000);
    endtask

    task automatic t_stcx;     // R5, R6
        step("R5", 1, 4, 6'h09, 0, 0, 0, 4'b0101, 1, 0, 4'b0101, 4'b0000);
        step("R5", 1, 4, 6'h0A, 0, 0, 0, 4'b1100, 0, 0, 4'b0000, 4'b0000);
        step("R6", 1, 3, 6'h0B, 1, 4, 6'h0C, 4'b1111, 1, 0, 4'b1000, 4'b0000);
    endtask

    task automatic t_isync;    // R7
        step("R7", 1, 5, 6'h0D, 1, 0, 6'h0E, 4'b1111, 1, 0, 4'b1111, 4'b0000);
        step("R7", 1, 5, 6'h0F, 0, 0, 0, 4'b0111, 0, 0, 4'b0000, 4'b0000);
    endtask

    task automatic t_order;    // R8
        step("R8", 0, 0, 6'h10, 1, 0, 6'h11, 4'b1111, 0, 0, 4'b0000, 4'b0000);
        step("R8", 1, 1, 6'h12, 1, 3, 6'h13, 4'b1110, 0, 0, 4'b0000, 4'b0000);
    endtask

    task automatic t_conflict; // R9
        step("R9", 1, 3, 6'h14, 1, 3, 6'h15, 4'b1111, 1, 0, 4'b1000, 4'b0000);
        step("R9", 1, 1, 6'h16, 1, 1, 6'h17, 4'b1111, 1, 0, 4'b0001, 4'b0000);
    endtask

    task automatic t_two_simple; // R10
        step("R10", 1, 0, 6'h18, 1, 0, 6'h19, 4'b1111, 1, 1, 4'b0001, 4'b0010);
        step("R10", 1, 2, 6'h1A, 1, 0, 6'h1B, 4'b1111, 1, 1, 4'b0100, 4'b0001);
    endtask

    task automatic t_reserved; // R11
        step("R11", 1, 6, 6'h1C, 0, 0, 0, 4'b1111, 0, 0, 4'b0000, 4'b0000);
        step("R11", 1, 2, 6'h1D, 1, 7, 6'h1E, 4'b1111, 1, 0, 4'b0100, 4'b0000);
    endtask

    task automatic t_timing;   // R12, R13
        step("R12", 1, 3, 6'h20, 0, 0, 0, 4'b1111, 1, 0, 4'b1000, 4'b0000);
        step("R12", 0, 0, 6'h21, 0, 0, 0, 4'b1111, 0, 0, 4'b0000, 4'b0000);
        step("R13", 1, 2, 6'h22, 1, 0, 6'h23, 4'b0000, 0, 0, 4'b0000, 4'b0000);
        step("R13", 1, 0, 6'h24, 1, 0, 6'h25, 4'b0010, 1, 0, 4'b0010, 4'b0000);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        t_reset();
        t_simple();
        t_complex();
        t_ldst_fp();
        t_stcx();
        t_isync();
        t_order();
        t_conflict();
        t_two_simple();
        t_reserved();
        t_timing();
        finish_run();
    end
endmodule